// File: doc/BRIEF.md
# Trail Trace Transmit Message Buffer

This block stores one trail trace message of sixteen octets in a small single-port RAM. A microprocessor loads and inspects the message over a simple request/wait bus. A framer collects the message one octet per fetch strobe and places each octet into the overhead of an outgoing frame. An internal four-bit octet pointer walks the message and wraps, so the framer sends the same message over and over. The block stores octets exactly as written. The firmware is responsible for the message format: the start octet carries its top bit set and a CRC-7 in the lower seven bits, and the other fifteen octets carry a clear top bit and a 7-bit ASCII character.

The RAM has one port, so processor accesses and framer fetches are arbitrated. A framer fetch always takes the RAM for the cycle in which it is raised. A processor request in that same cycle is stalled with `cpu_wait`. The request is granted in the first cycle without a fetch. The arbiter drives three controls: the address select that picks the pointer or the processor address, the RAM write strobe, and the output enable for the processor data bus buffers.

The arbiter keeps a record of who owned the RAM in the previous cycle. It has four states:
- `ST_IDLE`: no access.
- `ST_FRM`: a framer octet is on `frm_octet`.
- `ST_CPU_RD`: read data is driven onto the bus.
- `ST_CPU_WR`: a write has completed.

The next state is chosen in every cycle, whatever the current state:
- fetch raised goes to `ST_FRM`;
- otherwise a read request goes to `ST_CPU_RD`;
- otherwise a write request goes to `ST_CPU_WR`;
- otherwise the arbiter returns to `ST_IDLE`.

Top module: `tt_tx_buffer`

## Requirements
- R1: After reset the octet pointer is 0 and the arbiter is in `ST_IDLE`. With all inputs low, `cpu_wait`, `bus_oe`, `wr_strobe`, `addr_sel_frm` and `frm_valid` are 0, and `cpu_rdata` and `frm_octet` are 0.
- R2: A cycle with `frm_fetch` high reads the RAM at the octet pointer. In the next cycle `frm_valid` is 1 and `frm_octet` shows that octet.
- R3: The octet pointer advances by one after each fetch cycle and wraps from 15 to 0. It does not move in cycles without a fetch, including processor access cycles.
- R4: When `cpu_req` and `frm_fetch` are both high, `cpu_wait` is 1 and `wr_strobe` is 0. The addressed location is left unchanged, and `bus_oe` stays 0 in the next cycle.
- R5: A cycle with `cpu_req` high and `frm_fetch` low is a granted processor access, and `cpu_wait` is 0 in that cycle.
- R6: `wr_strobe` is 1 only in a granted cycle with `cpu_wr` = 1. That cycle stores all eight bits of `cpu_wdata` at `cpu_addr`, whatever their format.
- R7: A granted cycle with `cpu_wr` = 0 raises `bus_oe` in the next cycle, with `cpu_rdata` holding the octet at `cpu_addr`. `cpu_rdata` is 0 whenever `bus_oe` is 0.
- R8: `addr_sel_frm` is 1 exactly in cycles with `frm_fetch` high. `bus_oe` and `frm_valid` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 4 | Processor octet address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Read data, valid while bus_oe is 1, else 0 |
| cpu_wait | output | 1 | Processor stalled by a framer fetch |
| bus_oe | output | 1 | Output enable for the bus buffers |
| wr_strobe | output | 1 | RAM write strobe |
| addr_sel_frm | output | 1 | Address select: 1 = octet pointer, 0 = processor |
| frm_fetch | input | 1 | Framer fetch strobe |
| frm_valid | output | 1 | frm_octet carries a fetched octet |
| frm_octet | output | 8 | Fetched message octet, else 0 |

## Verification
The bench drives fetch bursts that run past octet 15, so a pointer that saturates or skips the wrap would send the wrong octet on the seventeenth fetch. It raises processor writes and reads in the very cycle a fetch is raised. A design that let the processor win, or leaked the write strobe, would corrupt a message octet or pop a read enable, and a later readback shows it. It interleaves idle cycles and processor cycles between fetches, so a pointer that advances on any RAM access shows up as a skipped octet. It also writes start-style octets into non-zero locations to catch a design that masks or checks the top bit.

// File: rtl/tt_pkg.sv
package tt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FRM    = 2'd1,
        ST_CPU_RD = 2'd2,
        ST_CPU_WR = 2'd3
    } tt_owner_e;
endpackage

// File: rtl/tt_arbiter.sv
module tt_arbiter
    import tt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frm_fetch,
    input  logic cpu_req,
    input  logic cpu_wr,
    output logic sel_frm,
    output logic wr_strobe,
    output logic rd_en,
    output logic cpu_wait,
    output logic bus_oe,
    output logic frm_valid
);
    tt_owner_e state, next_state;

    // ownership of the RAM in the current cycle; framer first
    always_comb begin
        if (frm_fetch)
            next_state = ST_FRM;
        else if (cpu_req && !cpu_wr)
            next_state = ST_CPU_RD;
        else if (cpu_req)
            next_state = ST_CPU_WR;
        else
            next_state = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= next_state;
    end

    // controls for the cycle being arbitrated
    always_comb begin
        sel_frm   = 1'b0;
        wr_strobe = 1'b0;
        rd_en     = 1'b0;
        unique case (next_state)
            ST_IDLE:   ;
            ST_FRM:    begin sel_frm = 1'b1; rd_en = 1'b1; end
            ST_CPU_RD: rd_en = 1'b1;
            ST_CPU_WR: wr_strobe = 1'b1;
        endcase
        cpu_wait = cpu_req && frm_fetch;
    end

    // outputs of the access completed last cycle
    always_comb begin
        bus_oe    = 1'b0;
        frm_valid = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_FRM:    frm_valid = 1'b1;
            ST_CPU_RD: bus_oe = 1'b1;
            ST_CPU_WR: ;
        endcase
    end
endmodule

// File: rtl/tt_octet_counter.sv
module tt_octet_counter #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (step)
            ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/tt_msg_ram.sv
module tt_msg_ram #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic          re,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (re)
            q <= mem[addr];
    end
endmodule

// File: rtl/tt_tx_buffer.sv
module tt_tx_buffer #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_wait,
    output logic          bus_oe,
    output logic          wr_strobe,
    output logic          addr_sel_frm,
    input  logic          frm_fetch,
    output logic          frm_valid,
    output logic [DW-1:0] frm_octet
);
    logic [AW-1:0] cnt;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_q;
    logic          ram_re;

    tt_arbiter i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_fetch (frm_fetch),
        .cpu_req   (cpu_req),
        .cpu_wr    (cpu_wr),
        .sel_frm   (addr_sel_frm),
        .wr_strobe (wr_strobe),
        .rd_en     (ram_re),
        .cpu_wait  (cpu_wait),
        .bus_oe    (bus_oe),
        .frm_valid (frm_valid)
    );

    tt_octet_counter #(.AW(AW)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (addr_sel_frm),
        .ptr   (cnt)
    );

    assign ram_addr = addr_sel_frm ? cnt : cpu_addr;

    tt_msg_ram #(.DW(DW), .DEPTH(DEPTH)) i_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (ram_addr),
        .we    (wr_strobe),
        .re    (ram_re),
        .wdata (cpu_wdata),
        .q     (ram_q)
    );

    assign cpu_rdata = bus_oe    ? ram_q : '0;
    assign frm_octet = frm_valid ? ram_q : '0;
endmodule

// File: rtl/tt_tx_buffer_chk.sv
module tt_tx_buffer_chk #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_wr,
    input logic          cpu_wait,
    input logic          bus_oe,
    input logic          wr_strobe,
    input logic          addr_sel_frm,
    input logic          frm_fetch,
    input logic          frm_valid,
    input logic [AW-1:0] cnt
);
    p_valid_after_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_fetch |=> frm_valid);
    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_fetch |=> cnt == AW'($past(cnt) + 1'b1));
    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_fetch |=> $stable(cnt));
    p_wait_on_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && frm_fetch) |-> (cpu_wait && !wr_strobe));
    p_no_oe_after_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_fetch |=> !bus_oe);
    p_grant_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !frm_fetch) |-> !cpu_wait);
    p_strobe_granted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> (cpu_req && cpu_wr && !frm_fetch));
    p_oe_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_wr && !frm_fetch) |=> bus_oe);
    p_sel_follows_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_sel_frm == frm_fetch);
    p_one_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_oe && frm_valid));
endmodule

bind tt_tx_buffer tt_tx_buffer_chk #(.AW(AW)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_wr       (cpu_wr),
    .cpu_wait     (cpu_wait),
    .bus_oe       (bus_oe),
    .wr_strobe    (wr_strobe),
    .addr_sel_frm (addr_sel_frm),
    .frm_fetch    (frm_fetch),
    .frm_valid    (frm_valid),
    .cnt          (cnt)
);

// File: tb/test_tt_tx_buffer.sv
`timescale 1ns/1ps
module test_tt_tx_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_wr = 1'b0, frm_fetch = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata, frm_octet;
    logic       cpu_wait, bus_oe, wr_strobe, addr_sel_frm, frm_valid;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model state
    int model_mem [16];
    int model_ptr = 0;
    int exp_valid = 0, exp_octet = 0, exp_oe = 0, exp_rdata = 0;

    always #4 clk = ~clk;

    tt_tx_buffer i_tt_tx_buffer (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_wait(cpu_wait), .bus_oe(bus_oe), .wr_strobe(wr_strobe),
        .addr_sel_frm(addr_sel_frm), .frm_fetch(frm_fetch),
        .frm_valid(frm_valid), .frm_octet(frm_octet)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // one clock: drive at negedge, check same-cycle controls, update model, check registered outputs
    task automatic step(input bit f, input bit rq, input bit wr, input int a, input int d);
        frm_fetch = f; cpu_req = rq; cpu_wr = wr; cpu_addr = 4'(a); cpu_wdata = 8'(d);
        #1;
        check("R4/R5 cpu_wait", cpu_wait, int'(rq && f));
        check("R6 wr_strobe", wr_strobe, int'(rq && wr && !f));
        check("R8 addr_sel_frm", addr_sel_frm, int'(f));
        @(posedge clk);
        exp_valid = 0; exp_oe = 0; exp_octet = 0; exp_rdata = 0;
        if (f) begin
            exp_valid = 1;
            exp_octet = model_mem[model_ptr];
            model_ptr = (model_ptr + 1) % 16;
        end else if (rq && wr) begin
            model_mem[a] = d & 8'hff;
        end else if (rq) begin
            exp_oe = 1;
            exp_rdata = model_mem[a];
        end
        @(negedge clk);
        check("R2 frm_valid", frm_valid, exp_valid);
        check("R2/R3 frm_octet", frm_octet, exp_octet);
        check("R7 bus_oe", bus_oe, exp_oe);
        check("R7 cpu_rdata", cpu_rdata, exp_rdata);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model_mem[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 cpu_wait", cpu_wait, 0);
        check("R1 bus_oe", bus_oe, 0);
        check("R1 frm_valid", frm_valid, 0);
        check("R1 frm_octet", frm_octet, 0);
        check("R1 cpu_rdata", cpu_rdata, 0);
        check("R1 wr_strobe", wr_strobe, 0);
        @(negedge clk);

        // R6: load a message; start octet 0x80|crc, ASCII after
        step(0, 1, 1, 0, 8'hB5);
        for (int i = 1; i < 16; i++) step(0, 1, 1, i, 8'h30 + i);
        // R7: read back some, with idle cycles between
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 1, 0, 9, 0);
        step(0, 1, 0, 15, 0);

        // R2/R3: twenty back-to-back fetches wrap the pointer past 15
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0);

        // R4: clash on write to 3 and on read of 5; pointer keeps walking
        step(1, 1, 1, 3, 8'hEE);
        step(1, 1, 0, 5, 0);
        // R5: granted in first free cycle; location 3 unchanged
        step(0, 1, 0, 3, 0);
        step(0, 1, 0, 5, 0);

        // R3: processor cycles and idles between fetches do not move the pointer
        step(1, 0, 0, 0, 0);
        step(0, 1, 0, 7, 0);
        step(0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0);
        step(0, 1, 1, 7, 8'h41);
        step(1, 0, 0, 0, 0);

        // R6: start-style octet in a non-zero slot stored unchanged
        step(0, 1, 1, 12, 8'hFF);
        step(0, 1, 0, 12, 0);
        // R4: clash held several cycles, then granted
        step(1, 1, 1, 12, 8'h00);
        step(1, 1, 1, 12, 8'h00);
        step(0, 1, 0, 12, 0);

        // fetch the rest of the way round and again
        for (int i = 0; i < 18; i++) step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        finish_run();
    end
endmodule